// File: doc/BRIEF.md
# I2C Serial-Memory Target Front End

This block is the bus-facing front end of a small serial memory attached to a two-wire I2C bus. It samples SCL and SDA with the system clock, finds the bus START and STOP conditions, and clocks in the selection byte that follows each START. A transfer is accepted only if the byte carries the fixed device prefix and the two strap-pin bits. The block acknowledges an accepted selection and then moves bytes between the bus and a plain local byte port. It never drives the bus high. It only pulls SDA low through an open-drain enable.

In write direction, every byte taken from the master is acknowledged and shown to the local side for one cycle on a valid strobe. In read direction, the block asks the local side for a byte with a one-cycle fetch strobe and shifts that byte out MSB first. It keeps sending bytes for as long as the master acknowledges them. Storage, word addressing, write-cycle timing and clock stretching belong to the surrounding memory.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, and until a START (SDA falling while SCL is high) has been seen, the block keeps `sda_oe` low and raises neither `wr_valid` nor `rd_fetch`, whatever SCL and SDA do.
- R2: A STOP (SDA rising while SCL is high) ends any transfer, including one in the middle of a byte. A partial byte produces no `wr_valid`. Afterwards the block stays silent until the next START.
- R3: Bits are taken on the SCL high phase, MSB first. The selection byte matches when bits 7..3 equal 1,0,1,0,0 and bits 2..1 equal `strap_a[1:0]`. Bit 0 gives the direction: 1 = read, 0 = write.
- R4: On a match, the block holds SDA low throughout the ninth SCL pulse of the selection byte.
- R5: On a mismatch in either the prefix or the strap bits, SDA stays released on the ninth pulse. No strobe or acknowledge follows until the next START.
- R6: In write direction, each complete byte raises `wr_valid` for exactly one cycle with that byte on `wr_data`, and SDA is held low during that byte's ninth pulse.
- R7: In read direction, the block pulses `rd_fetch` for one cycle and captures `rd_data` in that same cycle. It sends the byte MSB first on the next eight pulses (a 0 bit pulls SDA low) and releases SDA on the ninth.
- R8: If the master holds SDA low on the ninth pulse of a read byte, the next byte is fetched and sent. If SDA is high there, the block stops driving and ignores further clocks until a START.
- R9: A repeated START in the middle of a transfer restarts selection-byte reception without an intervening STOP.
- R10: `sda_oe` changes value only while SCL is low, just after a detected SCL falling edge, never during a stable SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_a | input | 2 | Strap pins compared with selection bits 2..1 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wr_valid | output | 1 | One-cycle strobe: `wr_data` holds a received byte |
| wr_data | output | 8 | Received write byte |
| rd_fetch | output | 1 | One-cycle strobe: `rd_data` is captured this cycle |
| rd_data | input | 8 | Byte to send on a read |

## Verification
Two events coincide in one cycle. At the SCL falling edge that closes the eighth bit of a write byte, the block hands the byte to the local port and also starts the acknowledge on SDA. The bench writes several byte values and checks two things for each: the logged byte matches what was sent, and the master sees SDA low in the mid-high sample of the ninth pulse. A bound property separately requires the strobe and the pull-down to be active together. A second pair is the condition detector and the byte engine acting during the same transfer. The bench provokes this with a STOP four bits into a byte and a repeated START in the middle of a byte. It then judges, at the ports, that no partial byte is delivered and that the new selection is acknowledged.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } tgt_state_e;

  // Selection match: prefix in bits 7..3, strap bits in 2..1.
  function automatic logic sel_match(input logic [7:0] sel,
                                     input logic [4:0] prefix,
                                     input logic [1:0] strap);
    return (sel[7:3] == prefix) && (sel[2:1] == strap);
  endfunction

  // Bit to present after n bits of a byte have already been clocked.
  function automatic logic next_tx_bit(input logic [7:0] b, input logic [3:0] n);
    logic [3:0] idx;
    idx = 4'd7 - n;
    return b[idx[2:0]];
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[DEPTH-2:0], line_i};
  end

  assign level_o = pipe[DEPTH-2];
  assign prev_o  = pipe[DEPTH-1];
  assign rise_o  = level_o & ~prev_o;
  assign fall_o  = ~level_o & prev_o;
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_lvl,
  input  logic sda_prev,
  output logic start_det,
  output logic stop_det
);
  logic scl_steady_hi;
  assign scl_steady_hi = scl_lvl & scl_prev;
  assign start_det     = scl_steady_hi & sda_prev & ~sda_lvl;
  assign stop_det      = scl_steady_hi & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [4:0] PREFIX = 5'b10100,
  parameter int         BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_fetch,
  output logic              busy
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W + 1);

  tgt_state_e        st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic              is_rd;
  logic              m_ack;

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_fetch <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_fetch <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (cnt < LAST_BIT) begin
            cnt <= cnt + 4'd1;
            if (st != ST_READ) sh <= {sh[BYTE_W-2:0], sda_lvl};
          end else if (cnt == LAST_BIT) begin
            cnt <= ACK_SLOT;
            if (st == ST_READ) begin
              m_ack <= ~sda_lvl;
              if (!sda_lvl) begin
                rd_fetch <= 1'b1;
                sh       <= rd_data;
              end
            end else if (st == ST_ADDR && is_rd) begin
              rd_fetch <= 1'b1;
              sh       <= rd_data;
            end
          end
        end else if (scl_fall) begin
          if (cnt == LAST_BIT) begin
            case (st)
              ST_ADDR: begin
                if (sel_match(sh, PREFIX, strap)) begin
                  sda_oe <= 1'b1;
                  is_rd  <= sh[0];
                end else begin
                  st  <= ST_IDLE;
                  cnt <= '0;
                end
              end
              ST_WRITE: begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_data  <= sh;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == ACK_SLOT) begin
            cnt <= '0;
            case (st)
              ST_ADDR: begin
                if (is_rd) begin
                  st     <= ST_READ;
                  sda_oe <= ~sh[BYTE_W-1];
                end else begin
                  st     <= ST_WRITE;
                  sda_oe <= 1'b0;
                end
              end
              ST_READ: begin
                if (m_ack) sda_oe <= ~sh[BYTE_W-1];
                else begin
                  st     <= ST_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == ST_READ && cnt != 4'd0) begin
            sda_oe <= ~next_tx_bit(sh, cnt);
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter logic [4:0] PREFIX      = 5'b10100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_a,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       rd_fetch,
  input  logic [7:0] rd_data
);
  localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [LINES-1:0] line_in, lvl, prv, rise, fall;
  logic scl_rise, scl_fall, start_det, stop_det, busy;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_in[g]),
      .level_o(lvl[g]),
      .prev_o (prv[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  assign scl_rise = rise[0];
  assign scl_fall = fall[0];

  i2c_bus_cond u_cond (
    .scl_lvl  (lvl[0]),
    .scl_prev (prv[0]),
    .sda_lvl  (lvl[1]),
    .sda_prev (prv[1]),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_engine #(.PREFIX(PREFIX), .BYTE_W(8)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (lvl[1]),
    .strap    (strap_a),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_fetch (rd_fetch),
    .busy     (busy)
  );
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det,
  input logic stop_det,
  input logic scl_fall,
  input logic sda_oe,
  input logic wr_valid,
  input logic rd_fetch,
  input logic busy
);
  logic seen_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_start <= 1'b0;
    else if (start_det) seen_start <= 1'b1;
  end

  AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> (!sda_oe && !wr_valid && !rd_fetch)); // R1

  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!busy && !sda_oe)); // R2

  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> sda_oe); // R6

  AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fetch |=> !rd_fetch); // R7

  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (busy && !sda_oe)); // R9

  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall)); // R10
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_det(start_det),
  .stop_det (stop_det),
  .scl_fall (scl_fall),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .rd_fetch (rd_fetch),
  .busy     (busy)
);

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int Q = 10;  // quarter SCL period in clk cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe, wr_valid, rd_fetch;
  logic [7:0] wr_data, rd_data;
  logic       sda_bus;

  int checks = 0, failures = 0;
  int oe_hits = 0, wr_cnt = 0, fetch_cnt = 0, r10_viol = 0, scl_hi = 0;
  logic prev_oe = 1'b0;
  logic [7:0] wr_log [16];
  logic [7:0] rd_mem [4] = '{8'h5A, 8'hC3, 8'h0F, 8'hFF};

  always #4 clk = ~clk;  // 125 MHz

  assign sda_bus = m_sda & ~sda_oe;
  assign rd_data = rd_mem[fetch_cnt % 4];

  i2c_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_a(strap),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_fetch(rd_fetch), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (sda_oe) oe_hits++;
    if (wr_valid) begin
      if (wr_cnt < 16) wr_log[wr_cnt] = wr_data;
      wr_cnt++;
    end
    if (rd_fetch) fetch_cnt++;
    scl_hi = m_scl ? scl_hi + 1 : 0;
    if (scl_hi > 5 && sda_oe !== prev_oe) r10_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic clock_bit(input logic drv, output logic smp);
    m_sda = drv; wq(Q); m_scl = 1'b1; wq(Q); smp = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); b[i] = s; end
    clock_bit(~give_ack, s);
  endtask

  task automatic t_no_start;
    logic a;
    oe_hits = 0; wr_cnt = 0;
    m_scl = 1'b0; wq(Q);
    send_byte(8'hA4, a); send_byte(8'h11, a);
    chk(oe_hits == 0, "R1 no drive without START", oe_hits, 0);
    chk(wr_cnt == 0 && fetch_cnt == 0, "R1 no strobes without START", wr_cnt + fetch_cnt, 0);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
  endtask

  task automatic t_write;
    logic a;
    logic [7:0] vals [3] = '{8'hA5, 8'h3C, 8'hFF};
    wr_cnt = 0;
    bus_start;
    send_byte(8'hA4, a);
    chk(a, "R4 ack on matching write select", a, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(vals[i], a);
      chk(a, "R6 write byte acked", a, 1);
    end
    chk(wr_cnt == 3, "R6 one strobe per byte", wr_cnt, 3);
    for (int i = 0; i < 3; i++)
      chk(wr_log[i] == vals[i], "R3 R6 byte MSB first", wr_log[i], vals[i]);
    bus_stop;
    m_scl = 1'b0; wq(Q);
    send_byte(8'hA4, a);
    chk(!a, "R2 silent after STOP", a, 0);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
  endtask

  task automatic t_mismatch(input logic [7:0] sel, input string tag);
    logic a;
    wr_cnt = 0;
    bus_start;
    send_byte(sel, a);
    chk(!a, tag, a, 0);
    oe_hits = 0;
    send_byte(8'h00, a);
    chk(oe_hits == 0 && wr_cnt == 0, "R5 ignored after mismatch", oe_hits + wr_cnt, 0);
    bus_stop;
  endtask

  task automatic t_read;
    logic a;
    logic [7:0] b;
    fetch_cnt = 0;
    bus_start;
    send_byte(8'hA5, a);
    chk(a, "R4 ack on matching read select", a, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i < 2, b);
      chk(b == rd_mem[i], "R7 read byte MSB first", b, rd_mem[i]);
    end
    chk(fetch_cnt == 3, "R8 fetch per acked byte", fetch_cnt, 3);
    oe_hits = 0;
    recv_byte(1'b0, b);
    chk(oe_hits == 0 && b == 8'hFF, "R8 released after NACK", b, 8'hFF);
    chk(fetch_cnt == 3, "R8 no fetch after NACK", fetch_cnt, 3);
    bus_stop;
  endtask

  task automatic t_rep_start;
    logic a, s;
    logic [7:0] b;
    wr_cnt = 0; fetch_cnt = 0;
    bus_start;
    send_byte(8'hA4, a);
    for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
    bus_start;
    send_byte(8'hA5, a);
    chk(a, "R9 repeated START reselects", a, 1);
    chk(wr_cnt == 0, "R9 no partial write", wr_cnt, 0);
    recv_byte(1'b0, b);
    chk(b == rd_mem[0], "R9 read after restart", b, rd_mem[0]);
    bus_stop;
  endtask

  task automatic t_early_stop;
    logic a, s;
    wr_cnt = 0;
    bus_start;
    send_byte(8'hA4, a);
    for (int i = 0; i < 4; i++) clock_bit(1'b1, s);
    bus_stop;
    chk(wr_cnt == 0, "R2 partial byte dropped", wr_cnt, 0);
    m_scl = 1'b0; wq(Q);
    send_byte(8'hA4, a);
    chk(!a, "R2 idle after early STOP", a, 0);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wq(5);
    chk(sda_oe == 0 && wr_valid == 0 && rd_fetch == 0, "R1 reset state",
        {sda_oe, wr_valid, rd_fetch}, 0);
    rst_n = 1'b1;
    wq(10);
    t_no_start;
    t_write;
    t_mismatch(8'hA2, "R5 strap mismatch not acked");
    t_mismatch(8'hB4, "R5 prefix mismatch not acked");
    t_read;
    t_rep_start;
    t_early_stop;
    chk(r10_viol == 0, "R10 no change while SCL high", r10_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule